// File: doc/BRIEF.md
# Eight-Level Interrupt Priority Controller

This block is the decision core of an eight-input interrupt controller. It collects requests into a request register, filters them through a mask register, and compares them against the levels that are already in service. When a request outranks everything in service, it raises an interrupt line toward the processor. Requests can be sampled as levels or caught on rising edges.

A single-cycle acknowledge strobe moves the winning level into the in-service register and presents an 8-bit vector built from a programmed 5-bit base and the 3-bit level code. A poll read does the same job as the acknowledge and returns a status byte instead of a vector. In-service bits are released by end-of-interrupt commands, or at acknowledge time when automatic release is on. The priority order is circular and is defined by a bottom pointer. That pointer can advance automatically to the level that was just serviced, or software can set it. A special mask mode lets every unmasked level through, whatever is in service.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset the request, in-service and mask registers are all zero, the bottom pointer is 7 (level 0 highest, level 7 lowest), special mask mode is off and `irq_out` is low.
- R2: With `cfg_edge`=0 the request register copies `irq_in` on every clock. With `cfg_edge`=1 a request bit is set on a rising edge of its line, holds until that level is taken by an acknowledge or poll, and is not set again while the line stays high.
- R3: A mask bit of 1 keeps its level from raising `irq_out` and from being taken. A mask bit of 0 lets the level through. The mask register is written through `mask_we`/`mask_wdata`.
- R4: `irq_out` is high exactly when some unmasked pending level has a higher priority than the highest-priority in-service level, or when some unmasked level is pending and nothing is in service.
- R5: `vector_out` is `{cfg_vec_base, code}`. The code is the winning level, or 7 when nothing is eligible. An `ack` with an eligible level sets that level's in-service bit. An `ack` with nothing eligible changes no state.
- R6: `cmd_op`=1 (nonspecific EOI) clears the highest-priority set in-service bit under the current order. `cmd_op`=2 (specific EOI) clears the bit named by `cmd_level`.
- R7: With `cfg_aeoi`=1 an acknowledge takes the level without setting its in-service bit.
- R8: With `cfg_rotate`=1, a nonspecific EOI or an automatic-release acknowledge makes the serviced level the lowest priority. For example, after level 4 the order from highest to lowest becomes 5,6,7,0,1,2,3,4.
- R9: `cmd_op`=3 sets the bottom-priority level to `cmd_level`. `cmd_op`=4 clears the in-service bit of `cmd_level` and also makes it the bottom level.
- R10: `cmd_op`=5 turns special mask mode on and `cmd_op`=6 turns it off. While it is on, in-service levels block only themselves, and any other unmasked pending level, higher or lower, is eligible.
- R11: `poll_data` is `{1'b1, 4'b0000, code}` when a level is eligible and 8'h00 otherwise. A `poll_rd` strobe takes the level exactly as `ack` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_in | input | 8 | Request lines, one per level |
| cfg_edge | input | 1 | 1 = rising-edge capture, 0 = level capture |
| cfg_aeoi | input | 1 | Automatic release of in-service on acknowledge |
| cfg_rotate | input | 1 | Rotate priority on nonspecific EOI or automatic release |
| cfg_vec_base | input | 5 | Upper five bits of the vector |
| mask_we | input | 1 | Mask register write strobe |
| mask_wdata | input | 8 | Mask value, 1 blocks a level |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code (see R6, R9, R10) |
| cmd_level | input | 3 | Level operand of a command |
| ack | input | 1 | Single-cycle acknowledge strobe |
| poll_rd | input | 1 | Poll read strobe, acts as acknowledge |
| irq_out | output | 1 | Interrupt request to the processor |
| vector_out | output | 8 | Base and winning level code |
| poll_data | output | 8 | Poll status byte |
| irr_out | output | 8 | Request register contents |
| isr_out | output | 8 | In-service register contents |

## Verification
On every cycle the assertions check these properties: a raised `irq_out` always has an unmasked pending request behind it, a take sets at most one new in-service bit and never a masked one, automatic release leaves the in-service register untouched, a nonspecific EOI removes at most one bit, and edge-captured requests are never dropped without a take. Only the bench's scenarios can show that the correct level wins. That covers the rotated orders after automatic and software rotation, the order at the wrap point, the special mask mode admitting a lower level, and the exact vector and poll codes. The bench checks them against a behavioural model on every clock.

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
  parameter int LEVELS = 8,
  localparam int CW = $clog2(LEVELS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LEVELS-1:0] irq_in,
  input  logic              cfg_edge,
  input  logic              cfg_aeoi,
  input  logic              cfg_rotate,
  input  logic [4:0]        cfg_vec_base,
  input  logic              mask_we,
  input  logic [LEVELS-1:0] mask_wdata,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [CW-1:0]     cmd_level,
  input  logic              ack,
  input  logic              poll_rd,
  output logic              irq_out,
  output logic [7:0]        vector_out,
  output logic [7:0]        poll_data,
  output logic [LEVELS-1:0] irr_out,
  output logic [LEVELS-1:0] isr_out
);

  logic [LEVELS-1:0] irr_q, isr_q, imr_q, prev_q, elig;
  logic [CW-1:0]     bottom_q;
  logic              smm_q;

  function automatic logic [CW:0] pick(input logic [LEVELS-1:0] v, input logic [CW-1:0] bot);
    logic [CW-1:0] l;
    pick = {1'b0, {CW{1'b1}}};
    for (int k = LEVELS - 1; k >= 0; k--) begin
      l = bot + CW'(k) + CW'(1);
      if (v[l]) pick = {1'b1, l};
    end
  endfunction

  logic [CW:0]   hi, win;
  logic [CW-1:0] hi_rank;
  logic          take;

  assign hi      = pick(isr_q, bottom_q);
  assign hi_rank = hi[CW-1:0] - bottom_q - CW'(1);

  always_comb begin
    for (int i = 0; i < LEVELS; i++) begin
      elig[i] = irr_q[i] & ~imr_q[i] &
                (smm_q ? ~isr_q[i]
                       : (!hi[CW] || ((CW'(i) - bottom_q - CW'(1)) < hi_rank)));
    end
  end

  assign win        = pick(elig, bottom_q);
  assign take       = (ack | poll_rd) & win[CW];
  assign irq_out    = win[CW];
  assign vector_out = {cfg_vec_base, win[CW-1:0]};
  assign poll_data  = win[CW] ? {1'b1, 4'b0000, win[CW-1:0]} : 8'h00;
  assign irr_out    = irr_q;
  assign isr_out    = isr_q;

  logic [LEVELS-1:0] isr_n, irr_n, take_oh;
  logic [CW-1:0]     bottom_n;
  logic              smm_n;

  assign take_oh = take ? (LEVELS'(1) << win[CW-1:0]) : '0;
  assign irr_n   = cfg_edge ? ((irr_q & ~take_oh) | (irq_in & ~prev_q)) : irq_in;

  always_comb begin
    isr_n    = isr_q;
    bottom_n = bottom_q;
    smm_n    = smm_q;
    if (take && cfg_aeoi && cfg_rotate) bottom_n = win[CW-1:0];
    if (cmd_valid) begin
      case (cmd_op)
        3'd1: if (hi[CW]) begin
                isr_n[hi[CW-1:0]] = 1'b0;
                if (cfg_rotate) bottom_n = hi[CW-1:0];
              end
        3'd2: isr_n[cmd_level] = 1'b0;
        3'd3: bottom_n = cmd_level;
        3'd4: begin
                isr_n[cmd_level] = 1'b0;
                bottom_n = cmd_level;
              end
        3'd5: smm_n = 1'b1;
        3'd6: smm_n = 1'b0;
        default: ;
      endcase
    end
    if (take && !cfg_aeoi) isr_n = isr_n | take_oh;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irr_q    <= '0;
      isr_q    <= '0;
      imr_q    <= '0;
      prev_q   <= '0;
      bottom_q <= CW'(LEVELS - 1);
      smm_q    <= 1'b0;
    end else begin
      irr_q    <= irr_n;
      isr_q    <= isr_n;
      prev_q   <= irq_in;
      bottom_q <= bottom_n;
      smm_q    <= smm_n;
      if (mask_we) imr_q <= mask_wdata;
    end
  end

endmodule

module irq_prio_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ack,
  input logic       poll_rd,
  input logic       cmd_valid,
  input logic [2:0] cmd_op,
  input logic       cfg_aeoi,
  input logic       cfg_edge,
  input logic       irq_out,
  input logic [7:0] irr_q,
  input logic [7:0] isr_q,
  input logic [7:0] imr_q
);

  a_r4_irq_has_source: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> ((irr_q & ~imr_q) != 8'h00));

  a_r5_one_new_service: assert property (@(posedge clk) disable iff (!rst_n)
    (ack || poll_rd) |=> $onehot0(isr_q & ~$past(isr_q)));

  a_r5_ack_adds_level: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq_out && !cfg_aeoi && !cmd_valid) |=>
      ($countones(isr_q) == $countones($past(isr_q)) + 1));

  a_r3_masked_never_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (ack || poll_rd) |=> ((isr_q & ~$past(isr_q) & $past(imr_q)) == 8'h00));

  a_r7_auto_release_keeps_isr: assert property (@(posedge clk) disable iff (!rst_n)
    ((ack || poll_rd) && cfg_aeoi && !cmd_valid) |=> (isr_q == $past(isr_q)));

  a_r6_eoi_removes_one: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd1 && !ack && !poll_rd) |=>
      (($countones(isr_q) + 1 == $countones($past(isr_q))) || ($past(isr_q) == 8'h00)));

  a_r2_edge_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_edge && !ack && !poll_rd) |=> ((~irr_q & $past(irr_q)) == 8'h00));

endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ack(ack), .poll_rd(poll_rd),
  .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cfg_aeoi(cfg_aeoi),
  .cfg_edge(cfg_edge), .irq_out(irq_out), .irr_q(irr_q),
  .isr_q(isr_q), .imr_q(imr_q)
);

// File: tb/irq_prio_ctrl_test.sv
module irq_prio_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] irq_in = 8'h00;
  logic       cfg_edge = 1'b0, cfg_aeoi = 1'b0, cfg_rotate = 1'b0;
  logic [4:0] cfg_vec_base = 5'h15;
  logic       mask_we = 1'b0;
  logic [7:0] mask_wdata = 8'h00;
  logic       cmd_valid = 1'b0;
  logic [2:0] cmd_op = 3'd0, cmd_level = 3'd0;
  logic       ack = 1'b0, poll_rd = 1'b0;
  logic       irq_out;
  logic [7:0] vector_out, poll_data, irr_out, isr_out;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_prio_ctrl uut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .cfg_edge(cfg_edge),
    .cfg_aeoi(cfg_aeoi), .cfg_rotate(cfg_rotate), .cfg_vec_base(cfg_vec_base),
    .mask_we(mask_we), .mask_wdata(mask_wdata), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cmd_level(cmd_level), .ack(ack), .poll_rd(poll_rd),
    .irq_out(irq_out), .vector_out(vector_out), .poll_data(poll_data),
    .irr_out(irr_out), .isr_out(isr_out)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  bit [7:0] m_irr = 0, m_isr = 0, m_imr = 0, m_prev = 0;
  int m_bot = 7;
  bit m_smm = 0;

  function automatic int m_lvl(input int r);
    return (m_bot + 1 + r) % 8;
  endfunction

  function automatic int m_hi();
    for (int r = 0; r < 8; r++) if (m_isr[m_lvl(r)]) return m_lvl(r);
    return -1;
  endfunction

  function automatic int m_win();
    int hr;
    int h;
    h = m_hi();
    hr = (h < 0) ? 8 : (h - m_bot + 7) % 8;
    for (int r = 0; r < 8; r++) begin
      int l;
      l = m_lvl(r);
      if (m_irr[l] && !m_imr[l] && (m_smm ? !m_isr[l] : r < hr)) return l;
    end
    return -1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_irr = 0; m_isr = 0; m_imr = 0; m_prev = 0; m_bot = 7; m_smm = 0;
    end else begin
      int w, h;
      bit tk;
      w = m_win();
      h = m_hi();
      tk = (ack || poll_rd) && w >= 0;
      for (int i = 0; i < 8; i++) begin
        if (cfg_edge)
          m_irr[i] = (m_irr[i] && !(tk && i == w)) || (irq_in[i] && !m_prev[i]);
        else
          m_irr[i] = irq_in[i];
      end
      m_prev = irq_in;
      if (tk && cfg_aeoi && cfg_rotate) m_bot = w;
      if (cmd_valid) begin
        if (cmd_op == 1 && h >= 0) begin m_isr[h] = 0; if (cfg_rotate) m_bot = h; end
        if (cmd_op == 2 || cmd_op == 4) m_isr[cmd_level] = 0;
        if (cmd_op == 3 || cmd_op == 4) m_bot = cmd_level;
        if (cmd_op == 5) m_smm = 1;
        if (cmd_op == 6) m_smm = 0;
      end
      if (tk && !cfg_aeoi) m_isr[w] = 1;
      if (mask_we) m_imr = mask_wdata;
    end
  end

  always @(negedge clk) if (!done) begin
    int w;
    w = m_win();
    chk("R4 model irq_out", irq_out, w >= 0);
    chk("R5 model vector", vector_out, {cfg_vec_base, (w >= 0) ? 3'(w) : 3'd7});
    chk("R11 model poll", poll_data, (w >= 0) ? {5'b10000, 3'(w)} : 8'h00);
    chk("R6 model isr", isr_out, m_isr);
    chk("R2 model irr", irr_out, m_irr);
  end

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_ack();
    ack = 1; tick(); ack = 0;
  endtask

  task automatic do_cmd(input logic [2:0] op, input logic [2:0] lvl);
    cmd_valid = 1; cmd_op = op; cmd_level = lvl; tick(); cmd_valid = 0;
  endtask

  task automatic do_mask(input logic [7:0] m);
    mask_we = 1; mask_wdata = m; tick(); mask_we = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    chk("R1 isr reset", isr_out, 0);
    chk("R1 irr reset", irr_out, 0);
    chk("R1 irq reset", irq_out, 0);
    rst_n = 1;
    tick();

    // level mode, fixed order
    irq_in = 8'h28; tick();
    chk("R2 level capture", irr_out, 8'h28);
    chk("R4 irq raised", irq_out, 1);
    chk("R5 vector level3", vector_out, 8'hAB);
    do_ack();
    chk("R5 isr after ack", isr_out, 8'h08);
    chk("R4 lower held off", irq_out, 0);
    irq_in = 8'h2A; tick();
    chk("R4 higher passes", irq_out, 1);
    do_ack();
    chk("R5 nested isr", isr_out, 8'h0A);
    do_cmd(3'd1, 3'd0);
    chk("R6 nonspecific eoi", isr_out, 8'h08);
    do_cmd(3'd2, 3'd3);
    chk("R6 specific eoi", isr_out, 8'h00);

    // mask
    do_mask(8'h02);
    chk("R3 masked skip", vector_out, 8'hAB);
    do_mask(8'h2A);
    chk("R3 all masked", irq_out, 0);
    do_mask(8'h00);

    // automatic release
    cfg_aeoi = 1;
    do_ack();
    chk("R7 isr untouched", isr_out, 8'h00);
    irq_in = 0; tick(); cfg_aeoi = 0;

    // automatic rotation in edge mode
    cfg_edge = 1; cfg_rotate = 1; cfg_aeoi = 1;
    irq_in = 8'h10; tick();
    chk("R2 edge capture", irr_out, 8'h10);
    do_ack();
    chk("R2 edge cleared on take", irr_out, 8'h00);
    tick();
    chk("R2 held line no reset", irr_out, 8'h00);
    irq_in = 8'h38; tick();
    chk("R2 only new edges", irr_out, 8'h28);
    chk("R8 after 4 level 5 wins", vector_out, 8'hAD);
    do_ack();
    chk("R8 wrap to level 3", vector_out, 8'hAB);
    do_ack();
    irq_in = 0; tick();
    cfg_aeoi = 0; cfg_rotate = 0;

    // software bottom
    do_cmd(3'd3, 3'd2);
    irq_in = 8'h0C; tick();
    chk("R9 bottom 2 gives 3", vector_out, 8'hAB);
    do_ack();
    chk("R9 level 2 lowest held", irq_out, 0);
    do_cmd(3'd4, 3'd3);
    chk("R9 eoi and bottom", isr_out, 8'h00);
    chk("R9 level 2 now wins", vector_out, 8'hAA);
    do_ack();
    irq_in = 0;
    do_cmd(3'd2, 3'd2);
    do_cmd(3'd3, 3'd7);

    // special mask mode
    irq_in = 8'h01; tick();
    do_ack();
    chk("R10 level 0 in service", isr_out, 8'h01);
    irq_in = 8'h41; tick();
    chk("R10 normal blocks lower", irq_out, 0);
    do_cmd(3'd5, 3'd0);
    chk("R10 special passes lower", irq_out, 1);
    do_ack();
    chk("R10 both in service", isr_out, 8'h41);
    do_cmd(3'd6, 3'd0);
    do_cmd(3'd2, 3'd0);
    do_cmd(3'd2, 3'd6);

    // poll
    irq_in = 0; tick();
    irq_in = 8'h80; tick();
    chk("R11 poll byte", poll_data, 8'h87);
    poll_rd = 1; tick(); poll_rd = 0;
    chk("R11 poll takes level", isr_out, 8'h80);
    chk("R11 poll empty", poll_data, 8'h00);
    chk("R5 spurious vector", vector_out, 8'hAF);
    do_ack();
    chk("R5 spurious no change", isr_out, 8'h80);
    do_cmd(3'd1, 3'd0);
    chk("R6 final eoi", isr_out, 8'h00);
    tick();

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule